// File: doc/BRIEF.md
# SPI Master Character Sequencer

This block drives one SPI peripheral as a bus master. It moves one character per transfer, from 8 to 16 bits long. The character goes out most significant bit first on the serial data output, and the reply comes in on the serial data input. The serial clock comes from the system clock through a modulus divider. A divisor of D gives a serial clock period of D system clocks. The single exception is D = 1, where the serial clock toggles on every system clock. The idle level of the clock is set by a polarity input, and a phase input selects which clock edge launches data and which edge captures it. Together these two inputs cover the four standard modes.

A transfer starts when `start` is high while `ready` is high. The `start_last` flag is taken with each start. When the chip select goes active at the start of a sequence, a programmable setup time runs before the first clock edge. After every character, the block waits for the idle half of the clock and then a programmable gap counted in units of 32 system clocks. If the character was marked last, the chip select is released at the end of that wait. Otherwise the chip select stays active, and the next character can be handed over during the wait so that its first clock edge follows without a break.

A divisor of zero is illegal. While the divisor is zero the block holds `ready` low and refuses every start, so the serial outputs never run from a meaningless setting.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` equals `cfg_cpol`, `done` is 0, and `ready` is 1 whenever `cfg_div` is nonzero.
- R2: While `cfg_div` is 0, `ready` is 0 and `start` is ignored, so `cs_n` stays 1 and `sck` does not toggle.
- R3: Within a character, the clock's active (non-idle) level lasts max(1, floor(D/2)) system clocks. Its idle level between two bits lasts ceil(D/2) system clocks. D is `cfg_div`.
- R4: The first clock transition comes `cfg_setup` system clocks after `cs_n` falls. When `cfg_setup` is 0, it comes ceil(D/2) system clocks after instead.
- R5: A `cfg_len` code c from 0 to 8 selects 8+c bits. Codes 9 to 15 select 8 bits. The number of leading (idle-to-active) clock edges per character equals the selected bit count N.
- R6: `mosi` carries the low N bits of `tx_data`, most significant first. With `cfg_cpha` = 0, data is stable at each leading edge and changes at trailing edges. With `cfg_cpha` = 1, data changes at leading edges and is stable at trailing edges.
- R7: `miso` is captured on the edge where `mosi` is stable. `rx_data` holds the N received bits right-aligned, with the upper bits zero. `done` is high for exactly one system clock, and that clock is the one in which the last trailing edge appears on `sck`.
- R8: A character started during the wait after the previous character has its first leading edge ceil(D/2) + 32*G system clocks after the previous character's last trailing edge. G is `cfg_gap`, so with G = 0 the clock runs on unbroken. If the wait is a single cycle (ceil(D/2) = 1 and G = 0), the start is taken one cycle later in a hold state, and the leading edge follows acceptance by ceil(D/2).
- R9: After a character sent with `start_last` = 1, `cs_n` rises ceil(D/2) + 32*G system clocks after the last trailing edge. `cs_n` is 0 whenever `done` is 1.
- R10: `ready` is high in idle, in the hold state, and during the post-character wait. The exceptions are the wait's final cycle, the case where a next character is already taken, and the case where the finished character was marked last.
- R11: While `cs_n` is 1, `sck` rests at the `cfg_cpol` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 8 | Serial clock divisor, 1 to 255 (0 blocks transfers) |
| cfg_setup | input | 8 | Chip-select-to-first-edge delay in system clocks (0 means half a clock period) |
| cfg_gap | input | 8 | Post-character gap in units of 32 system clocks |
| cfg_len | input | 4 | Character length code |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| start | input | 1 | Request to send `tx_data` |
| start_last | input | 1 | Release chip select after this character |
| tx_data | input | 16 | Character to send, right-aligned |
| ready | output | 1 | A start is accepted in this cycle |
| done | output | 1 | One-cycle pulse when `rx_data` is valid |
| rx_data | output | 16 | Received character, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The chip select falls in the cycle after a start is accepted. Every clock edge, the `done` pulse and the chip-select release then land at fixed system-clock counts from earlier events: the setup delay, the active and idle half lengths, and the idle half plus 32 times the gap. The bench stamps every port change with a cycle counter that it reads half a clock after the active edge. It then compares each time difference with the value worked out from the divisor, setup, gap and length settings. The sweep covers all four modes, divisors whose halves come out even, odd and of length one, and both valid and reserved length codes, and each setting is run in two-character bursts. In those bursts the second start is issued at the first sample point after `done`, so the window-or-hold choice that R8 describes follows from the settings alone.

// File: rtl/spi_seq_pkg.sv
// Shared types and helpers for the SPI character sequencer.
// Assumes characters are between MIN_BITS and MAX_BITS long.
package spi_seq_pkg;
    localparam int MIN_BITS    = 8;
    localparam int MAX_BITS    = 16;
    localparam int LEN_CODE_W  = 4;
    localparam int CHAR_BITS_W = $clog2(MAX_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,   // chip select released
        ST_LEAD,   // waiting for the next leading edge
        ST_ACT,    // clock at active level, waiting for trailing edge
        ST_TAIL,   // idle half after the last bit of a character
        ST_GAP,    // programmable gap after the tail
        ST_HOLD    // chip select held, no character pending
    } seq_state_e;

    // Map a length code to a bit count; out-of-range codes fall back to the minimum.
    function automatic logic [CHAR_BITS_W-1:0] char_bits(input logic [LEN_CODE_W-1:0] code);
        if (int'(code) <= MAX_BITS - MIN_BITS)
            return CHAR_BITS_W'(MIN_BITS + int'(code));
        else
            return CHAR_BITS_W'(MIN_BITS);
    endfunction
endpackage

// File: rtl/spi_seq_timing.sv
// Converts the divisor, setup and gap settings into interval lengths in system
// clocks. Purely combinational. Assumes CNT_W is wide enough for GAP_SCALE times
// the largest gap setting.
module spi_seq_timing #(
    parameter int DIV_W     = 8,
    parameter int DLY_W     = 8,
    parameter int GAP_SCALE = 32,
    parameter int CNT_W     = 14
) (
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [DLY_W-1:0] cfg_setup,
    input  logic [DLY_W-1:0] cfg_gap,
    output logic [CNT_W-1:0] act_len,
    output logic [CNT_W-1:0] idle_len,
    output logic [CNT_W-1:0] setup_len,
    output logic [CNT_W-1:0] gap_len
);
    logic [CNT_W-1:0] div_x;
    logic [CNT_W-1:0] half_dn;

    // Split the divisor into a longer idle half and a shorter active half.
    always_comb begin
        div_x     = CNT_W'(cfg_div);
        half_dn   = div_x >> 1;
        idle_len  = (div_x + CNT_W'(1)) >> 1;
        act_len   = (half_dn == '0) ? CNT_W'(1) : half_dn;
        setup_len = (cfg_setup == '0) ? idle_len : CNT_W'(cfg_setup);
        gap_len   = CNT_W'(cfg_gap) * CNT_W'(GAP_SCALE);
    end
endmodule

// File: rtl/spi_seq_timer.sv
// Single down-counter shared by every interval of the sequencer. A load starts
// an interval of load_val cycles; expire is high in its final cycle.
// Assumes load_val is never zero when load is asserted.
module spi_seq_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Count down from the loaded length and park at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expire = (cnt_q == CNT_W'(1));

    // A zero-length interval would never expire and stall the sequence.
    p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
endmodule

// File: rtl/spi_seq_shifter.sv
// Transmit and receive shift registers for one character. The transmit word is
// left-aligned on load so its top bit leaves first. Edge events come from the
// sequencer and the registered mosi changes on the edge that cfg_cpha assigns.
// Assumes load, lead_ev and trail_ev never coincide.
module spi_seq_shifter
    import spi_seq_pkg::*;
#(
    parameter int W  = MAX_BITS,
    parameter int BW = CHAR_BITS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_data,
    input  logic [BW-1:0] nbits,
    input  logic          cpha,
    input  logic          lead_ev,
    input  logic          trail_ev,
    input  logic          last_bit,
    input  logic          miso,
    output logic          mosi,
    output logic [W-1:0]  rx_data
);
    logic [W-1:0]  tx_q;
    logic [W-1:0]  rx_q;
    logic [W-1:0]  rx_out_q;
    logic [W-1:0]  aligned;
    logic [BW-1:0] shamt;
    logic          mosi_q;

    // Left-align the outgoing character by its bit count.
    always_comb begin
        shamt   = BW'(W) - nbits;
        aligned = load_data << shamt;
    end

    // Launch and capture bits on the edges chosen by the phase setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            rx_q     <= '0;
            rx_out_q <= '0;
            mosi_q   <= 1'b0;
        end else if (load) begin
            rx_q <= '0;
            if (!cpha) begin
                mosi_q <= aligned[W-1];
                tx_q   <= aligned << 1;
            end else begin
                tx_q   <= aligned;
            end
        end else if (lead_ev) begin
            if (cpha) begin
                mosi_q <= tx_q[W-1];
                tx_q   <= tx_q << 1;
            end else begin
                rx_q   <= {rx_q[W-2:0], miso};
            end
        end else if (trail_ev) begin
            if (cpha) begin
                rx_q <= {rx_q[W-2:0], miso};
                if (last_bit)
                    rx_out_q <= {rx_q[W-2:0], miso};
            end else if (last_bit) begin
                rx_out_q <= rx_q;
            end else begin
                mosi_q <= tx_q[W-1];
                tx_q   <= tx_q << 1;
            end
        end
    end

    assign mosi    = mosi_q;
    assign rx_data = rx_out_q;

    // At most one of load and the two edge events is active in any cycle.
    p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, lead_ev, trail_ev}));
endmodule

// File: rtl/spi_xfer_seq.sv
// SPI master character sequencer. It asserts chip select, waits out the setup
// time, then runs N clock periods, each made of an active half and an idle half.
// After each character it waits the idle half plus the programmed gap. A start
// accepted during that wait keeps chip select active and chains the next
// character. Assumes configuration inputs are static while cs_n is low.
module spi_xfer_seq
    import spi_seq_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DLY_W     = 8,
    parameter int GAP_SCALE = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic [DLY_W-1:0]      cfg_setup,
    input  logic [DLY_W-1:0]      cfg_gap,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic                  start,
    input  logic                  start_last,
    input  logic [MAX_BITS-1:0]   tx_data,
    output logic                  ready,
    output logic                  done,
    output logic [MAX_BITS-1:0]   rx_data,
    output logic                  sck,
    output logic                  mosi,
    input  logic                  miso,
    output logic                  cs_n
);
    localparam int GAP_CNT_W = DLY_W + $clog2(GAP_SCALE) + 1;
    localparam int CNT_W     = (GAP_CNT_W > DIV_W + 1) ? GAP_CNT_W : DIV_W + 1;

    seq_state_e             state_q;
    logic [CHAR_BITS_W-1:0] bits_left_q;
    logic [CHAR_BITS_W-1:0] nbits;
    logic                   pend_q;
    logic                   last_q;
    logic                   cs_n_q;
    logic                   sck_q;
    logic                   done_q;

    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] idle_len;
    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] gap_len;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_expire;

    logic div_ok;
    logic gap_zero;
    logic in_window;
    logic window_end;
    logic accept;
    logic lead_ev;
    logic trail_ev;
    logic last_bit;

    spi_seq_timing #(
        .DIV_W     (DIV_W),
        .DLY_W     (DLY_W),
        .GAP_SCALE (GAP_SCALE),
        .CNT_W     (CNT_W)
    ) timing_i (
        .cfg_div   (cfg_div),
        .cfg_setup (cfg_setup),
        .cfg_gap   (cfg_gap),
        .act_len   (act_len),
        .idle_len  (idle_len),
        .setup_len (setup_len),
        .gap_len   (gap_len)
    );

    spi_seq_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_expire)
    );

    // Decode events and the acceptance window from state and timer.
    always_comb begin
        nbits      = char_bits(cfg_len);
        div_ok     = (cfg_div != '0);
        gap_zero   = (cfg_gap == '0);
        in_window  = (state_q == ST_TAIL) || (state_q == ST_GAP);
        window_end = t_expire && (((state_q == ST_TAIL) && gap_zero) || (state_q == ST_GAP));
        ready      = div_ok && ((state_q == ST_IDLE) || (state_q == ST_HOLD) ||
                                (in_window && !pend_q && !last_q && !window_end));
        accept     = start && ready;
        lead_ev    = ((state_q == ST_LEAD) && t_expire) || (window_end && pend_q);
        trail_ev   = (state_q == ST_ACT) && t_expire;
        last_bit   = (bits_left_q == CHAR_BITS_W'(1));
    end

    // Pick which interval the shared timer starts next.
    always_comb begin
        t_load = 1'b0;
        t_val  = idle_len;
        if (accept && (state_q == ST_IDLE)) begin
            t_load = 1'b1;
            t_val  = setup_len;
        end else if (accept && (state_q == ST_HOLD)) begin
            t_load = 1'b1;
            t_val  = idle_len;
        end else if (lead_ev) begin
            t_load = 1'b1;
            t_val  = act_len;
        end else if (trail_ev) begin
            t_load = 1'b1;
            t_val  = idle_len;
        end else if ((state_q == ST_TAIL) && t_expire && !gap_zero) begin
            t_load = 1'b1;
            t_val  = gap_len;
        end
    end

    // Sequence state, chip select, serial clock level and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bits_left_q <= '0;
            pend_q      <= 1'b0;
            last_q      <= 1'b0;
            cs_n_q      <= 1'b1;
            sck_q       <= cfg_cpol;
            done_q      <= 1'b0;
        end else begin
            done_q <= trail_ev && last_bit;
            if (accept) begin
                bits_left_q <= nbits;
                last_q      <= start_last;
            end
            if (lead_ev)
                sck_q <= ~cfg_cpol;
            else if (trail_ev || (state_q == ST_IDLE))
                sck_q <= cfg_cpol;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    cs_n_q  <= 1'b0;
                    state_q <= ST_LEAD;
                end
                ST_LEAD: if (t_expire)
                    state_q <= ST_ACT;
                ST_ACT: if (t_expire) begin
                    if (last_bit) begin
                        state_q <= ST_TAIL;
                    end else begin
                        bits_left_q <= bits_left_q - CHAR_BITS_W'(1);
                        state_q     <= ST_LEAD;
                    end
                end
                ST_TAIL, ST_GAP: begin
                    if (accept)
                        pend_q <= 1'b1;
                    if (window_end) begin
                        if (pend_q) begin
                            pend_q  <= 1'b0;
                            state_q <= ST_ACT;
                        end else if (last_q) begin
                            cs_n_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_HOLD;
                        end
                    end else if ((state_q == ST_TAIL) && t_expire) begin
                        state_q <= ST_GAP;
                    end
                end
                ST_HOLD: if (accept)
                    state_q <= ST_LEAD;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    spi_seq_shifter #(
        .W  (MAX_BITS),
        .BW (CHAR_BITS_W)
    ) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (tx_data),
        .nbits     (nbits),
        .cpha      (cfg_cpha),
        .lead_ev   (lead_ev),
        .trail_ev  (trail_ev),
        .last_bit  (last_bit),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data)
    );

    assign cs_n = cs_n_q;
    assign sck  = sck_q;
    assign done = done_q;

    // A zero divisor never lets the chip select go active.
    p_refuse_div0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && (cfg_div == '0)) |=> cs_n);

    // The released bus keeps the clock at its idle level.
    p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $stable(cfg_cpol)) |-> (sck == cfg_cpol));

    // Completion is a single-cycle pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Chip select is still active when a character completes.
    p_cs_held_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cs_n);

    // No start is taken in the cycle the post-character wait closes.
    p_no_accept_at_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        window_end |-> !ready);
endmodule

// File: tb/spi_xfer_seq_tb.sv
// Sweep bench: bursts of two characters over modes, divisors, length codes,
// setup and gap values. Edge times are stamped with a cycle counter read at the
// falling clock edge and compared with arithmetically derived intervals.
module spi_xfer_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd4;
    logic [7:0]  cfg_setup = 8'd0;
    logic [7:0]  cfg_gap = 8'd0;
    logic [3:0]  cfg_len = 4'd0;
    logic        cfg_cpol = 1'b1;
    logic        cfg_cpha = 1'b0;
    logic        start = 1'b0;
    logic        start_last = 1'b0;
    logic [15:0] tx_data = 16'h0;
    logic        ready;
    logic        done;
    logic [15:0] rx_data;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;
    logic        cs_n;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Monitor records
    int lead_t[0:31];
    int trail_t[0:31];
    int done_t[0:1];
    int acc_t[0:1];
    logic [15:0] rx_got[0:1];
    logic [15:0] mo_got[0:1];
    int nl, nt, nd, cs_fall_t, cs_rise_t, n_cs_fall, sj, mon_n;
    logic [15:0] macc;
    logic [15:0] sword;
    logic prev_sck, prev_cs;

    spi_xfer_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_div    (cfg_div),
        .cfg_setup  (cfg_setup),
        .cfg_gap    (cfg_gap),
        .cfg_len    (cfg_len),
        .cfg_cpol   (cfg_cpol),
        .cfg_cpha   (cfg_cpha),
        .start      (start),
        .start_last (start_last),
        .tx_data    (tx_data),
        .ready      (ready),
        .done       (done),
        .rx_data    (rx_data),
        .sck        (sck),
        .mosi       (mosi),
        .miso       (miso),
        .cs_n       (cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
                     req, got, got, exp, exp, cyc);
        end
    endtask

    task automatic mon_clear();
        nl = 0; nt = 0; nd = 0; n_cs_fall = 0; sj = 0;
        cs_fall_t = -1; cs_rise_t = -1; macc = '0;
    endtask

    // Slave model and event stamps, half a clock after each active edge.
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            cs_fall_t = cyc;
            n_cs_fall++;
            sj = 0;
            if (!cfg_cpha) miso = sword[mon_n-1];
        end
        if (!prev_cs && cs_n) cs_rise_t = cyc;
        if (!cs_n && (sck != prev_sck)) begin
            if (sck != cfg_cpol) begin
                if (nl < 32) lead_t[nl] = cyc;
                nl++;
                if (!cfg_cpha) macc = {macc[14:0], mosi};
                else miso = sword[mon_n-1-sj];
            end else begin
                if (nt < 32) trail_t[nt] = cyc;
                nt++;
                if (cfg_cpha) macc = {macc[14:0], mosi};
                sj++;
                if (sj == mon_n) sj = 0;
                if (!cfg_cpha) miso = sword[mon_n-1-sj];
            end
        end
        if (done) begin
            if (nd < 2) begin
                done_t[nd] = cyc;
                rx_got[nd] = rx_data;
                mo_got[nd] = macc;
            end
            nd++;
            macc = '0;
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    // One two-character burst with its interval checks.
    task automatic burst(input int d, input int s, input int g, input int code,
                         input logic pol, input logic pha, input int idx);
        int n, hh, ll, sx, mask, exp_lead;
        logic [15:0] txw[0:1];
        n    = (code <= 8) ? 8 + code : 8;
        hh   = (d / 2 == 0) ? 1 : d / 2;
        ll   = (d + 1) / 2;
        sx   = (s == 0) ? ll : s;
        mask = (1 << n) - 1;
        @(negedge clk);
        cfg_div = 8'(d); cfg_setup = 8'(s); cfg_gap = 8'(g);
        cfg_len = 4'(code); cfg_cpol = pol; cfg_cpha = pha;
        sword  = 16'h6A5C ^ 16'(idx * 16'h0913);
        mon_n  = n;
        txw[0] = 16'hB4E1 + 16'(idx * 16'h3791);
        txw[1] = 16'h5D27 ^ 16'(idx * 16'h1C0B);
        repeat (2) @(negedge clk);
        mon_clear();
        check("R11 idle level", int'(sck), int'(pol));
        for (int c = 0; c < 2; c++) begin
            if (c > 0) while (!done) @(negedge clk);
            while (!ready) @(negedge clk);
            start = 1'b1; tx_data = txw[c]; start_last = (c == 1);
            acc_t[c] = cyc + 1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
        // R5: leading edge count
        check("R5 leading edges", nl, 2 * n);
        check("R7 done count", nd, 2);
        if (nl != 2 * n || nt != 2 * n) return;
        // R4: setup delay
        check("R4 setup", lead_t[0] - cs_fall_t, sx);
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < n; i++) begin
                int k;
                k = c * n + i;
                check("R3 active half", trail_t[k] - lead_t[k], hh);
                if (i > 0) check("R3 idle half", lead_t[k] - trail_t[k-1], ll);
            end
            check("R7 done timing", done_t[c], trail_t[c*n+n-1]);
            check("R7 rx data", int'(rx_got[c]), int'(sword) & mask);
            check("R6 mosi bits", int'(mo_got[c]), int'(txw[c]) & mask);
        end
        // R8: chained character start
        exp_lead = (ll == 1 && g == 0) ? acc_t[1] + ll : trail_t[n-1] + ll + 32 * g;
        check("R8 chain gap", lead_t[n], exp_lead);
        // R9: release after the final wait
        check("R9 cs release", cs_rise_t - trail_t[2*n-1], ll + 32 * g);
        check("R9 single select", n_cs_fall, 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int idx;
        int divs[4];
        int codes[4];
        divs  = '{1, 2, 3, 5};
        codes = '{0, 3, 8, 12};
        prev_sck = 1'b1; prev_cs = 1'b1; mon_n = 8; sword = '0;
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 cs_n", int'(cs_n), 1);
        check("R1 sck", int'(sck), 1);
        check("R1 done", int'(done), 0);
        check("R1 ready", int'(ready), 1);
        // R2: zero divisor refuses starts
        cfg_div = 8'd0;
        @(negedge clk);
        mon_clear();
        check("R2 ready low", int'(ready), 0);
        start = 1'b1; start_last = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 cs_n held", n_cs_fall, 0);
        check("R2 sck quiet", nl + nt, 0);
        cfg_div = 8'd4;
        @(negedge clk);
        check("R10 ready idle", int'(ready), 1);
        idx = 0;
        for (int m = 0; m < 4; m++) begin
            for (int di = 0; di < 4; di++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    burst(divs[di], (idx % 3 == 0) ? 0 : ((idx % 3 == 1) ? 3 : 1),
                          idx % 2, codes[ci], m[1], m[0], idx);
                    idx++;
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule